// File: doc/BRIEF.md
# RC Oscillator Trim Calibrator

This block tunes an on-chip RC oscillator against a crystal-timed frequency counter. It runs a binary search over an integer trim setting. For each candidate setting it drives the matching trim code to the oscillator and fires a one-cycle start pulse at the external counter. It then waits for the counter's handshake and compares the returned count with a fixed target. When the search ends, the block presents the final code with its enable bit set and raises a hold request so that the code survives power-down. A done level tells the system that the code is valid.

The search length is fixed at eight measurements and does not depend on the counts. Counts close enough to the target leave the setting where it is. The step starts at half the trim range and is halved after every measurement, rounding up. The integer setting is never driven out as plain binary: it is spread over seven 4-bit nibbles, and the nibble values differ from one another by at most one.

Top module: `rc_trim_calib`

## Requirements
- R1: A one-cycle `calStart` pulse while the engine is idle starts a calibration. One cycle later `calBusy` is 1 and `calDone`, `trimEn` and `trimHold` are 0. A `calStart` pulse while `calBusy` is 1 has no effect.
- R2: Before its first measurement start, a calibration drives `measRstN` low for exactly one cycle. It then pulses `measLoadWr` once, with `measLoad` equal to the target count 2048. `trimHold` and `trimEn` stay 0 whenever `measStart` is 1.
- R3: Every calibration issues exactly 8 `measStart` pulses, each one cycle long.
- R4: After each start the engine ignores `measCount` until `measDone` has first been seen low and then seen high. The counter may keep `measDone` high for up to two cycles after a start.
- R5: Let diff = 2048 − `measCount`. If diff lies within −12..+12 inclusive, the trim setting stays unchanged.
- R6: The setting starts at 0 and the step starts at 56. If diff > 12 the setting decreases by step/2 (rounded down). If diff < −12 it increases by step/2. After every measurement the step becomes (step+1)>>1.
- R7: The setting is signed. It is clamped to 0..111 before it is encoded, so a negative setting drives the code for 0.
- R8: For a value v, let base = v/7 and mod = v%7. Nibble d of `trimCode` (bits 4d+3..4d, d = 0..6) carries base when d ≤ mod and (base−1) mod 16 otherwise. For example, value 0 gives 0xFFFFFF0.
- R9: When the search ends, `trimCode` holds the encoded final setting, and `trimEn`, `trimHold` and `calDone` are 1 while `calBusy` is 0. These outputs keep their values until the next accepted start.
- R10: After reset, `calBusy`, `calDone`, `trimEn`, `trimHold`, `measStart` and `measLoadWr` are 0, `measRstN` is 1 and `trimCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calStart | input | 1 | One-cycle request to run a calibration |
| measDone | input | 1 | Counter completion level |
| measCount | input | 16 | Count returned by the counter |
| measRstN | output | 1 | Active-low reset to the counter |
| measLoadWr | output | 1 | Write strobe for the target load value |
| measLoad | output | 16 | Target load value |
| measStart | output | 1 | One-cycle measurement request |
| trimCode | output | 28 | Seven-nibble trim code to the oscillator |
| trimEn | output | 1 | Trim code valid and enabled |
| trimHold | output | 1 | Request to retain the code over power-down |
| calBusy | output | 1 | Calibration in progress |
| calDone | output | 1 | Calibration finished, code final |

## Verification
A corrupt setting or step register shows up at the ports within one measurement. The next code applied before `measStart` no longer matches the code the bench predicts, and the bench's counter model then returns a different count. The final code then differs from the bench's own search. A wrong iteration count changes the number of start pulses seen before `calDone` rises. A control state that skips the low phase of the handshake takes the stale count left by the counter reset and steers the search the wrong way. Clamping and the dead-band edges (differences of exactly 12 and 13) are driven by a counter model that returns a constant count.

// File: rtl/rct_pkg.sv
package rct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTLO,
    ST_LOAD,
    ST_APPLY,
    ST_START,
    ST_WAITLO,
    ST_WAITHI,
    ST_FINAL
  } calState_t;

  typedef struct packed {
    logic init;
    logic apply;
    logic eval;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/rct_trim_encoder.sv
module rct_trim_encoder #(
  parameter int VAL_W   = 7,
  parameter int NIBBLES = 7,
  parameter int NIB_W   = 4
) (
  input  logic [VAL_W-1:0]         trimVal,
  output logic [NIBBLES*NIB_W-1:0] trimCode
);

  int baseVal;
  int remVal;

  assign baseVal = int'(trimVal) / NIBBLES;
  assign remVal  = int'(trimVal) % NIBBLES;

  for (genvar d = 0; d < NIBBLES; d++) begin : gNib
    assign trimCode[d*NIB_W +: NIB_W] =
      (d <= remVal) ? NIB_W'(baseVal) : NIB_W'(baseVal - 1);
  end

endmodule

// File: rtl/rct_datapath.sv
module rct_datapath import rct_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int TARGET   = 2048,
  parameter int TOL      = 12,
  parameter int MAX_TRIM = 112,
  parameter int ITERS    = 8,
  parameter int NIBBLES  = 7,
  parameter int NIB_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               strobe,
  input  logic [CNT_W-1:0]         measCount,
  output logic                     lastIter,
  output logic [NIBBLES*NIB_W-1:0] trimCode,
  output logic                     trimEn,
  output logic                     trimHold,
  output logic                     calDone
);

  localparam int VAL_W  = $clog2(MAX_TRIM);
  localparam int SET_W  = VAL_W + 2;
  localparam int STEP_W = VAL_W + 1;
  localparam int ITER_W = $clog2(ITERS) + 1;
  localparam int DIFF_W = CNT_W + 2;
  localparam int CODE_W = NIBBLES * NIB_W;
  localparam logic signed [SET_W-1:0]  SET_MAX = SET_W'(MAX_TRIM - 1);
  localparam logic signed [DIFF_W-1:0] TGT_S   = DIFF_W'(TARGET);
  localparam logic signed [DIFF_W-1:0] TOL_S   = DIFF_W'(TOL);
  localparam logic [STEP_W-1:0]        STEP0   = STEP_W'(MAX_TRIM / 2);

  logic signed [SET_W-1:0]  setting;
  logic [STEP_W-1:0]        step;
  logic [ITER_W-1:0]        iter;
  logic [VAL_W-1:0]         clampVal;
  logic [CODE_W-1:0]        nextCode;
  logic signed [DIFF_W-1:0] diff;
  logic signed [SET_W-1:0]  moveAmt;

  always_comb begin
    if (setting < 0)             clampVal = '0;
    else if (setting > SET_MAX)  clampVal = VAL_W'(MAX_TRIM - 1);
    else                         clampVal = setting[VAL_W-1:0];
  end

  rct_trim_encoder #(
    .VAL_W  (VAL_W),
    .NIBBLES(NIBBLES),
    .NIB_W  (NIB_W)
  ) uEnc (
    .trimVal (clampVal),
    .trimCode(nextCode)
  );

  assign diff     = TGT_S - $signed({2'b00, measCount});
  assign moveAmt  = $signed(SET_W'(step >> 1));
  assign lastIter = (iter == ITER_W'(ITERS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setting  <= '0;
      step     <= STEP0;
      iter     <= '0;
      trimCode <= '0;
      trimEn   <= 1'b0;
      trimHold <= 1'b0;
      calDone  <= 1'b0;
    end else begin
      if (strobe.init) begin
        setting  <= '0;
        step     <= STEP0;
        iter     <= '0;
        trimEn   <= 1'b0;
        trimHold <= 1'b0;
        calDone  <= 1'b0;
      end
      if (strobe.apply) begin
        trimCode <= nextCode;
      end
      if (strobe.eval) begin
        if (diff > TOL_S)       setting <= setting - moveAmt;
        else if (diff < -TOL_S) setting <= setting + moveAmt;
        step <= STEP_W'((step + 1'b1) >> 1);
        iter <= iter + 1'b1;
      end
      if (strobe.finish) begin
        trimCode <= nextCode;
        trimEn   <= 1'b1;
        trimHold <= 1'b1;
        calDone  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rct_control.sv
module rct_control import rct_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calStart,
  input  logic       measDone,
  input  logic       lastIter,
  output ctlStrobe_t strobe,
  output logic       calBusy,
  output logic       measRstN,
  output logic       measLoadWr,
  output logic       measStart
);

  calState_t state;
  calState_t stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (calStart) stateNext = ST_RSTLO;
      ST_RSTLO:  stateNext = ST_LOAD;
      ST_LOAD:   stateNext = ST_APPLY;
      ST_APPLY:  stateNext = ST_START;
      ST_START:  stateNext = ST_WAITLO;
      ST_WAITLO: if (!measDone) stateNext = ST_WAITHI;
      ST_WAITHI: if (measDone) stateNext = lastIter ? ST_FINAL : ST_APPLY;
      ST_FINAL:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.init   = (state == ST_IDLE) && calStart;
  assign strobe.apply  = (state == ST_APPLY);
  assign strobe.eval   = (state == ST_WAITHI) && measDone;
  assign strobe.finish = (state == ST_FINAL);

  assign calBusy    = (state != ST_IDLE);
  assign measRstN   = (state != ST_RSTLO);
  assign measLoadWr = (state == ST_LOAD);
  assign measStart  = (state == ST_START);

endmodule

// File: rtl/rc_trim_calib.sv
module rc_trim_calib import rct_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int TARGET   = 2048,
  parameter int TOL      = 12,
  parameter int MAX_TRIM = 112,
  parameter int ITERS    = 8,
  parameter int NIBBLES  = 7,
  parameter int NIB_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     calStart,
  input  logic                     measDone,
  input  logic [CNT_W-1:0]         measCount,
  output logic                     measRstN,
  output logic                     measLoadWr,
  output logic [CNT_W-1:0]         measLoad,
  output logic                     measStart,
  output logic [NIBBLES*NIB_W-1:0] trimCode,
  output logic                     trimEn,
  output logic                     trimHold,
  output logic                     calBusy,
  output logic                     calDone
);

  ctlStrobe_t strobe;
  logic       lastIter;

  assign measLoad = CNT_W'(TARGET);

  rct_control uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .calStart  (calStart),
    .measDone  (measDone),
    .lastIter  (lastIter),
    .strobe    (strobe),
    .calBusy   (calBusy),
    .measRstN  (measRstN),
    .measLoadWr(measLoadWr),
    .measStart (measStart)
  );

  rct_datapath #(
    .CNT_W   (CNT_W),
    .TARGET  (TARGET),
    .TOL     (TOL),
    .MAX_TRIM(MAX_TRIM),
    .ITERS   (ITERS),
    .NIBBLES (NIBBLES),
    .NIB_W   (NIB_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .measCount(measCount),
    .lastIter (lastIter),
    .trimCode (trimCode),
    .trimEn   (trimEn),
    .trimHold (trimHold),
    .calDone  (calDone)
  );

endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
  parameter int CNT_W  = 16,
  parameter int TARGET = 2048
) (
  input logic             clk,
  input logic             rstN,
  input logic             measRstN,
  input logic             measLoadWr,
  input logic [CNT_W-1:0] measLoad,
  input logic             measStart,
  input logic             trimEn,
  input logic             trimHold,
  input logic             calBusy,
  input logic             calDone
);

  AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    measStart |-> calBusy); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    measStart |=> !measStart); // R3

  AST_LOAD_AFTER_CNT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    measLoadWr |-> (!$past(measRstN) && measLoad == CNT_W'(TARGET))); // R2

  AST_MEASURE_UNHELD: assert property (@(posedge clk) disable iff (!rstN)
    measStart |-> (!trimHold && !trimEn)); // R2

  AST_DONE_WITH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> (trimHold && trimEn && !calBusy)); // R9

  AST_DONE_CLEARED_BY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calDone) |-> calBusy); // R1

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(calDone && calBusy)); // R9

endmodule

bind rc_trim_calib rct_checker #(
  .CNT_W (CNT_W),
  .TARGET(TARGET)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .measRstN  (measRstN),
  .measLoadWr(measLoadWr),
  .measLoad  (measLoad),
  .measStart (measStart),
  .trimEn    (trimEn),
  .trimHold  (trimHold),
  .calBusy   (calBusy),
  .calDone   (calDone)
);

// File: tb/sim_rc_trim_calib.sv
module sim_rc_trim_calib;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        calStart = 1'b0;
  logic        measDone;
  logic [15:0] measCount;
  logic        measRstN;
  logic        measLoadWr;
  logic [15:0] measLoad;
  logic        measStart;
  logic [27:0] trimCode;
  logic        trimEn;
  logic        trimHold;
  logic        calBusy;
  logic        calDone;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  rc_trim_calib u0 (
    .clk(clk), .rstN(rstN), .calStart(calStart), .measDone(measDone),
    .measCount(measCount), .measRstN(measRstN), .measLoadWr(measLoadWr),
    .measLoad(measLoad), .measStart(measStart), .trimCode(trimCode),
    .trimEn(trimEn), .trimHold(trimHold), .calBusy(calBusy), .calDone(calDone)
  );

  // ---------------- reference functions from the requirements ----------
  function automatic logic [27:0] refEncode(int v);
    logic [27:0] c = '0;
    int b = v / 7;
    int m = v % 7;
    for (int d = 0; d < 7; d++) begin
      int nib = (d <= m) ? b : b - 1;
      c |= 28'(nib & 15) << (4 * d);
    end
    return c;
  endfunction

  function automatic int refDecode(logic [27:0] c);
    for (int v = 0; v < 112; v++) if (refEncode(v) == c) return v;
    return 0;
  endfunction

  bit mUseConst;
  int mConst;
  int mTrue;
  int mSlope;

  function automatic int modelCount(int s);
    if (mUseConst) return mConst;
    return 2048 - mSlope * (s - mTrue);
  endfunction

  function automatic int clampSet(int s);
    if (s < 0) return 0;
    if (s > 111) return 111;
    return s;
  endfunction

  function automatic int goldSearch();
    int s = 0;
    int st = 56;
    for (int i = 0; i < 8; i++) begin
      int diff = 2048 - modelCount(clampSet(s));
      if (diff > 12) s -= st / 2;
      else if (diff < -12) s += st / 2;
      st = (st + 1) >> 1;
    end
    return clampSet(s);
  endfunction

  // ---------------- frequency counter model ---------------------------
  int mSet = 0;
  int mTimer = 0;
  int mPhase = 0;

  always @(posedge clk) begin
    if (!rstN || !measRstN) begin
      measDone  <= 1'b1;
      measCount <= 16'd0;
      mPhase    <= 0;
    end else if (measStart) begin
      mSet   <= refDecode(trimCode);
      mTimer <= 2;
      mPhase <= 1;
    end else if (mPhase == 1) begin
      if (mTimer == 1) begin
        measDone <= 1'b0;
        mTimer   <= 6;
        mPhase   <= 2;
      end else mTimer <= mTimer - 1;
    end else if (mPhase == 2) begin
      if (mTimer == 1) begin
        measCount <= 16'(modelCount(mSet));
        measDone  <= 1'b1;
        mPhase    <= 0;
      end else mTimer <= mTimer - 1;
    end
  end

  // ---------------- port monitors -------------------------------------
  int  totStarts = 0;
  int  totRstLow = 0;
  int  totLoadOk = 0;
  int  startNoLoad = 0;
  int  holdBad = 0;
  bit  loaded = 1'b0;

  always @(posedge clk) begin
    if (rstN) begin
      if (measStart) totStarts++;
      if (!measRstN) begin totRstLow++; loaded = 1'b0; end
      if (measLoadWr) begin
        if (measLoad == 16'd2048) totLoadOk++;
        loaded = 1'b1;
      end
      if (measStart && !loaded) startNoLoad++;
      if (measStart && (trimHold || trimEn)) holdBad++;
    end
  end

  // ---------------- helpers -------------------------------------------
  task automatic chk(string req, string what, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) calStart = 1'b1;
    @(negedge clk) calStart = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!calDone && n < 5000) begin @(negedge clk); n++; end
    chk("R9", "calDone reached", longint'(calDone), 1);
  endtask

  task automatic runAndCheck(string req, string name);
    int gold = goldSearch();
    int s0 = totStarts, r0 = totRstLow, l0 = totLoadOk;
    int n0 = startNoLoad, h0 = holdBad;
    pulseStart();
    waitDone();
    chk(req, {name, " final code"}, longint'(trimCode), longint'(refEncode(gold)));
    chk("R9", {name, " enable"}, longint'(trimEn), 1);
    chk("R9", {name, " hold"}, longint'(trimHold), 1);
    chk("R9", {name, " not busy"}, longint'(calBusy), 0);
    chk("R3", {name, " start count"}, totStarts - s0, 8);
    chk("R2", {name, " counter reset cycles"}, totRstLow - r0, 1);
    chk("R2", {name, " target load writes"}, totLoadOk - l0, 1);
    chk("R2", {name, " start before load"}, startNoLoad - n0, 0);
    chk("R2", {name, " start while held"}, holdBad - h0, 0);
  endtask

  task automatic setRamp(int t, int sl);
    mUseConst = 1'b0; mTrue = t; mSlope = sl;
  endtask

  task automatic setConst(int c);
    mUseConst = 1'b1; mConst = c;
  endtask

  // ---------------- scenarios -----------------------------------------
  task automatic tReset();
    @(negedge clk);
    chk("R10", "busy", longint'(calBusy), 0);
    chk("R10", "done", longint'(calDone), 0);
    chk("R10", "enable", longint'(trimEn), 0);
    chk("R10", "hold", longint'(trimHold), 0);
    chk("R10", "start", longint'(measStart), 0);
    chk("R10", "load strobe", longint'(measLoadWr), 0);
    chk("R10", "counter reset", longint'(measRstN), 1);
    chk("R10", "code", longint'(trimCode), 0);
  endtask

  task automatic tSearch();
    setRamp(20, 5); runAndCheck("R6", "ramp20");   // R4 R8
    setRamp(37, 5); runAndCheck("R6", "ramp37");
    setRamp(50, 3); runAndCheck("R8", "ramp50");
  endtask

  task automatic tDeadBand();
    setConst(2060); runAndCheck("R5", "diff -12");
    chk("R5", "diff -12 stays 0", longint'(trimCode), 28'hFFFFFF0);
    setConst(2036); runAndCheck("R5", "diff +12");
    setConst(2061); runAndCheck("R6", "diff -13");
    chk("R6", "diff -13 climbs to 55", longint'(trimCode), longint'(refEncode(55)));
  endtask

  task automatic tClamp();
    setConst(2035); runAndCheck("R7", "diff +13");
    chk("R7", "negative setting encodes 0", longint'(trimCode), 28'hFFFFFF0);
  endtask

  task automatic tBusyIgnore();
    int s0;
    int gold;
    setRamp(33, 4);
    gold = goldSearch();
    s0 = totStarts;
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    waitDone();
    chk("R1", "restart while busy ignored: starts", totStarts - s0, 8);
    chk("R1", "restart while busy ignored: code", longint'(trimCode), longint'(refEncode(gold)));
    repeat (3) @(negedge clk);
    chk("R1", "idle after run", longint'(calBusy), 0);
  endtask

  task automatic tHoldAndRestart();
    logic [27:0] kept = trimCode;
    repeat (20) @(negedge clk);
    chk("R9", "done level held", longint'(calDone), 1);
    chk("R9", "code held", longint'(trimCode), longint'(kept));
    setRamp(10, 6);
    pulseStart();
    chk("R1", "restart busy", longint'(calBusy), 1);
    chk("R1", "restart clears done", longint'(calDone), 0);
    chk("R1", "restart clears enable", longint'(trimEn), 0);
    chk("R1", "restart clears hold", longint'(trimHold), 0);
    waitDone();
    chk("R8", "restart final code", longint'(trimCode), longint'(refEncode(goldSearch())));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    nChk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    mUseConst = 1'b1; mConst = 2048; mTrue = 0; mSlope = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSearch();
    tDeadBand();
    tClamp();
    tBusyIgnore();
    tHoldAndRestart();
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule